// File: doc/BRIEF.md
# RV32I Integer Execute Unit

This combinational unit carries out the integer arithmetic, comparison, logic and shift instructions of the 32-bit base integer instruction set. It handles both the register-register and the register-immediate forms, plus the two upper-immediate forms that load a constant or add one to the program counter. Each cycle the issue stage presents one instruction word, the two source register values and the program counter of that instruction. The unit returns the value for the destination register and a write strobe for the register file.

The unit decodes the opcode and function fields itself. It builds the sign-extended 12-bit immediate or the 20-bit upper immediate, and then selects one of the adder, comparator, logic or shifter results. It never signals an arithmetic exception, and overflow simply wraps. Writes to register zero are suppressed, so the canonical no-op retires with no effect. Loads, stores, branches, jumps and system instructions are decoded as unsupported. For those the unit drives a zero result with the strobe low.

Top module: `rv32_int_exec`

## Requirements
- R1: Opcode 0110011 with funct3 000 adds rs1 and rs2, or subtracts rs2 from rs1 when instruction bit 30 is 1. Opcode 0010011 with funct3 000 adds the sign-extended instr[31:20] to rs1 and ignores bit 30. All sums keep only the low 32 bits, wrapping without any flag.
- R2: funct3 010 (register form, or immediate form with the sign-extended immediate) writes 1 when rs1 is less than the second operand as signed two's complement, else 0.
- R3: funct3 011 performs the same comparison unsigned. The immediate is sign-extended first, so an immediate of 1 gives 1 only for rs1 = 0, and an immediate of -1 compares against 0xFFFFFFFF. The register form with rs1 = 0 gives 1 exactly when rs2 is nonzero.
- R4: funct3 100/110/111 give XOR/OR/AND of rs1 with rs2 or with the sign-extended immediate. XOR with immediate -1 inverts rs1.
- R5: funct3 001 shifts left and funct3 101 shifts right, logically when bit 30 is 0 and arithmetically when bit 30 is 1. The amount is instr[24:20] in the immediate form and rs2[4:0] in the register form, and upper bits of rs2 are ignored. Left and logical right shifts fill with zeros, and the arithmetic right shift fills with copies of the original bit 31.
- R6: Opcode 0110111 writes {instr[31:12], 12'h000}.
- R7: Opcode 0010111 writes pc + {instr[31:12], 12'h000}, modulo 2^32.
- R8: The write strobe is high only for the four opcodes above with instr[11:7] nonzero. When instr[11:7] is 0 (for example ADDI x0,x0,0) the strobe is low. Any other opcode drives strobe low and result 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word being executed |
| rs1_i | input | 32 | Value of the first source register |
| rs2_i | input | 32 | Value of the second source register |
| pc_i | input | 32 | Address of the instruction |
| result_o | output | 32 | Value for the destination register |
| rd_we_o | output | 1 | Destination register write strobe |

## Verification
The bench targets the points where an integer unit typically goes wrong. A decoder that looks at bit 30 for the immediate add would corrupt ADDI whenever the immediate has bit 10 set. Mixing up signed and unsigned comparison flips SLT against SLTU for operands of opposite sign, and zero-extending the SLTIU immediate makes a compare against -1 fail. Right shifts of a negative word expose a missing sign fill. A register shift by 32 or by 0xFFFFFFE1 exposes the use of more than five amount bits. Register-zero destinations and non-integer opcodes check that the strobe falls low, which catches a unit that would corrupt the zero register or write on a load.

// File: rtl/rv32_exec_pkg.sv
package rv32_exec_pkg;
  localparam int XLEN = 32;
  localparam int SHW  = $clog2(XLEN);

  localparam logic [6:0] OPC_REG  = 7'b0110011;
  localparam logic [6:0] OPC_IMM  = 7'b0010011;
  localparam logic [6:0] OPC_LUI  = 7'b0110111;
  localparam logic [6:0] OPC_AUI  = 7'b0010111;

  typedef enum logic [3:0] {
    EX_ADD, EX_SUB, EX_SLL, EX_SLT, EX_SLTU, EX_XOR,
    EX_SRL, EX_SRA, EX_OR, EX_AND, EX_LUI, EX_AUIPC, EX_NONE
  } ex_op_e;
endpackage

// File: rtl/rv32_exec_decode.sv
module rv32_exec_decode
  import rv32_exec_pkg::*;
(
  input  logic [31:0]     instr_i,
  output ex_op_e          op_o,
  output logic            use_imm_o,
  output logic [XLEN-1:0] imm_o,
  output logic            we_o
);
  logic [6:0] opc;
  logic [2:0] f3;
  logic       b30;
  logic [XLEN-1:0] imm_i, imm_u;

  assign opc   = instr_i[6:0];
  assign f3    = instr_i[14:12];
  assign b30   = instr_i[30];
  assign imm_i = {{(XLEN-12){instr_i[31]}}, instr_i[31:20]};
  assign imm_u = {instr_i[31:12], 12'h000};

  always_comb begin
    op_o      = EX_NONE;
    use_imm_o = 1'b0;
    imm_o     = imm_i;
    unique case (opc)
      OPC_REG, OPC_IMM: begin
        use_imm_o = (opc == OPC_IMM);
        unique case (f3)
          3'b000:  op_o = (b30 && opc == OPC_REG) ? EX_SUB : EX_ADD;
          3'b001:  op_o = EX_SLL;
          3'b010:  op_o = EX_SLT;
          3'b011:  op_o = EX_SLTU;
          3'b100:  op_o = EX_XOR;
          3'b101:  op_o = b30 ? EX_SRA : EX_SRL;
          3'b110:  op_o = EX_OR;
          default: op_o = EX_AND;
        endcase
      end
      OPC_LUI: begin op_o = EX_LUI;   use_imm_o = 1'b1; imm_o = imm_u; end
      OPC_AUI: begin op_o = EX_AUIPC; use_imm_o = 1'b1; imm_o = imm_u; end
      default: ;
    endcase
  end

  assign we_o = (op_o != EX_NONE) && (instr_i[11:7] != 5'd0);
endmodule

// File: rtl/rv32_exec_shift.sv
module rv32_exec_shift
  import rv32_exec_pkg::*;
(
  input  logic [XLEN-1:0] d_i,
  input  logic [SHW-1:0]  amt_i,
  input  logic            left_i,
  input  logic            arith_i,
  output logic [XLEN-1:0] q_o
);
  logic            fill;
  logic [XLEN-1:0] stg [SHW+1];
  logic [XLEN-1:0] rd_out;

  assign fill = arith_i & d_i[XLEN-1];

  // left shift = bit-reverse, right shift, bit-reverse
  for (genvar i = 0; i < XLEN; i++) begin : g_rev
    assign stg[0][i] = left_i ? d_i[XLEN-1-i] : d_i[i];
    assign q_o[i]    = left_i ? rd_out[XLEN-1-i] : rd_out[i];
  end

  for (genvar s = 0; s < SHW; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign stg[s+1] = amt_i[s] ? {{STEP{fill}}, stg[s][XLEN-1:STEP]} : stg[s];
  end

  assign rd_out = stg[SHW];

  always_comb begin
    if (amt_i == '0) p_zero_amt_pass_r5: assert (q_o == d_i);
    if (arith_i && !left_i && amt_i != '0)
      p_sign_fill_r5: assert (q_o[XLEN-1] == d_i[XLEN-1]);
  end
endmodule

// File: rtl/rv32_exec_cmp.sv
module rv32_exec_cmp
  import rv32_exec_pkg::*;
(
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            lt_s_o,
  output logic            lt_u_o
);
  logic [XLEN:0] diff;

  assign diff   = {1'b0, a_i} - {1'b0, b_i};
  assign lt_u_o = diff[XLEN];
  assign lt_s_o = (a_i[XLEN-1] ^ b_i[XLEN-1]) ? a_i[XLEN-1] : diff[XLEN];

  always_comb begin
    if (b_i == '0) p_nothing_below_zero_r3: assert (!lt_u_o);
    if (a_i[XLEN-1] && !b_i[XLEN-1]) p_neg_below_pos_r2: assert (lt_s_o && !lt_u_o);
  end
endmodule

// File: rtl/rv32_int_exec.sv
module rv32_int_exec
  import rv32_exec_pkg::*;
(
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] rs2_i,
  input  logic [XLEN-1:0] pc_i,
  output logic [XLEN-1:0] result_o,
  output logic            rd_we_o
);
  ex_op_e          op;
  logic            use_imm;
  logic [XLEN-1:0] imm;
  logic [XLEN-1:0] opa, opb, sum, dif, shq;
  logic            lt_s, lt_u;

  rv32_exec_decode u_dec (
    .instr_i   (instr_i),
    .op_o      (op),
    .use_imm_o (use_imm),
    .imm_o     (imm),
    .we_o      (rd_we_o)
  );

  assign opa = (op == EX_AUIPC) ? pc_i : rs1_i;
  assign opb = use_imm ? imm : rs2_i;
  assign sum = opa + opb;
  assign dif = opa - opb;

  rv32_exec_cmp u_cmp (
    .a_i    (opa),
    .b_i    (opb),
    .lt_s_o (lt_s),
    .lt_u_o (lt_u)
  );

  rv32_exec_shift u_shf (
    .d_i     (opa),
    .amt_i   (opb[SHW-1:0]),
    .left_i  (op == EX_SLL),
    .arith_i (op == EX_SRA),
    .q_o     (shq)
  );

  always_comb begin
    unique case (op)
      EX_ADD, EX_AUIPC: result_o = sum;
      EX_SUB:           result_o = dif;
      EX_SLT:           result_o = {{(XLEN-1){1'b0}}, lt_s};
      EX_SLTU:          result_o = {{(XLEN-1){1'b0}}, lt_u};
      EX_XOR:           result_o = opa ^ opb;
      EX_OR:            result_o = opa | opb;
      EX_AND:           result_o = opa & opb;
      EX_SLL, EX_SRL, EX_SRA: result_o = shq;
      EX_LUI:           result_o = opb;
      default:          result_o = '0;
    endcase
  end

  always_comb begin
    if (instr_i[11:7] == 5'd0) p_x0_never_written_r8: assert (!rd_we_o);
    if (instr_i[6:0] == OPC_LUI) p_upper_low_zero_r6: assert (result_o[11:0] == 12'h000);
    if (instr_i[6:0] == OPC_AUI) p_auipc_low_bits_r7: assert (result_o[11:0] == pc_i[11:0]);
    if ((instr_i[6:0] == OPC_REG || instr_i[6:0] == OPC_IMM) && instr_i[14:13] == 2'b01)
      p_compare_is_bool_r2: assert (result_o[XLEN-1:1] == '0);
  end
endmodule

// File: tb/rv32_int_exec_bench.sv
`timescale 1ns/1ps
module rv32_int_exec_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] instr, rs1, rs2, pc, res;
  logic        we;
  int n_chk = 0, n_bad = 0;

  rv32_int_exec u_rv32_int_exec (
    .instr_i(instr), .rs1_i(rs1), .rs2_i(rs2), .pc_i(pc),
    .result_o(res), .rd_we_o(we)
  );

  typedef struct packed {
    logic [31:0] ins, a, b, pc, exp;
    logic        we;
    logic [3:0]  req;
  } vec_t;

  function automatic logic [31:0] r_ins(logic sub, logic [2:0] f3, logic [4:0] rd);
    return {1'b0, sub, 5'd0, 5'd2, 5'd1, f3, rd, 7'b0110011};
  endfunction
  function automatic logic [31:0] i_ins(logic [11:0] imm, logic [2:0] f3, logic [4:0] rd);
    return {imm, 5'd1, f3, rd, 7'b0010011};
  endfunction
  function automatic vec_t mk(logic [31:0] ins, a, b, p, e, logic w, logic [3:0] r);
    return '{ins:ins, a:a, b:b, pc:p, exp:e, we:w, req:r};
  endfunction

  localparam int NV = 31;
  localparam vec_t VEC [NV] = '{
    mk(r_ins(0,3'b000,5'd3), 32'hFFFF_FFFF, 32'h2, 0, 32'h1, 1, 1),              // R1 wrap
    mk(r_ins(1,3'b000,5'd3), 32'h5, 32'h7, 0, 32'hFFFF_FFFE, 1, 1),              // R1 sub
    mk(i_ins(12'h001,3'b000,5'd4), 32'h7FFF_FFFF, 0, 0, 32'h8000_0000, 1, 1),     // R1 overflow
    mk(i_ins(12'h400,3'b000,5'd4), 32'h1, 32'h9, 0, 32'h401, 1, 1),              // R1 bit30 ignored
    mk(r_ins(0,3'b010,5'd5), 32'hFFFF_FFFF, 32'h1, 0, 32'h1, 1, 2),              // R2
    mk(r_ins(0,3'b010,5'd5), 32'h1, 32'hFFFF_FFFF, 0, 32'h0, 1, 2),              // R2
    mk(i_ins(12'hFFD,3'b010,5'd5), 32'hFFFF_FFFB, 0, 0, 32'h1, 1, 2),            // R2 -5<-3
    mk(r_ins(0,3'b011,5'd6), 32'h0, 32'h5, 0, 32'h1, 1, 3),                      // R3 snez
    mk(r_ins(0,3'b011,5'd6), 32'h0, 32'h0, 0, 32'h0, 1, 3),                      // R3
    mk(r_ins(0,3'b011,5'd6), 32'h1, 32'hFFFF_FFFF, 0, 32'h1, 1, 3),              // R3 vs signed
    mk(i_ins(12'h001,3'b011,5'd6), 32'h0, 0, 0, 32'h1, 1, 3),                    // R3 seqz
    mk(i_ins(12'h001,3'b011,5'd6), 32'h7, 0, 0, 32'h0, 1, 3),                    // R3
    mk(i_ins(12'hFFF,3'b011,5'd6), 32'h8000_0000, 0, 0, 32'h1, 1, 3),            // R3 imm -1
    mk(i_ins(12'hFFF,3'b100,5'd7), 32'h1234_5678, 0, 0, 32'hEDCB_A987, 1, 4),    // R4 not
    mk(i_ins(12'h800,3'b111,5'd7), 32'hFFFF_FFFF, 0, 0, 32'hFFFF_F800, 1, 4),    // R4
    mk(i_ins(12'h0F0,3'b110,5'd7), 32'h0000_0F00, 0, 0, 32'h0000_0FF0, 1, 4),    // R4
    mk(r_ins(0,3'b111,5'd7), 32'hF0F0_F0F0, 32'hFF00_FF00, 0, 32'hF000_F000, 1, 4), // R4
    mk(r_ins(0,3'b110,5'd7), 32'hF0F0_F0F0, 32'h0F00_0000, 0, 32'hFFF0_F0F0, 1, 4), // R4
    mk(r_ins(0,3'b100,5'd7), 32'hFFFF_0000, 32'hF0F0_F0F0, 0, 32'h0F0F_F0F0, 1, 4), // R4
    mk(i_ins(12'h004,3'b001,5'd8), 32'h8000_0001, 0, 0, 32'h0000_0010, 1, 5),    // R5
    mk(i_ins(12'h004,3'b101,5'd8), 32'h8000_0000, 0, 0, 32'h0800_0000, 1, 5),    // R5
    mk(i_ins(12'h404,3'b101,5'd8), 32'h8000_0000, 0, 0, 32'hF800_0000, 1, 5),    // R5 srai
    mk(r_ins(1,3'b101,5'd8), 32'h8000_0000, 32'hFFFF_FFE1, 0, 32'hC000_0000, 1, 5), // R5
    mk(r_ins(0,3'b101,5'd8), 32'h8000_0000, 32'd31, 0, 32'h1, 1, 5),             // R5
    mk(r_ins(0,3'b001,5'd8), 32'h1234, 32'd32, 0, 32'h1234, 1, 5),               // R5 low bits
    mk({20'hABCDE,5'd9,7'b0110111}, 32'h5555_5555, 0, 0, 32'hABCD_E000, 1, 6),   // R6
    mk({20'h00001,5'd9,7'b0010111}, 32'h77, 0, 32'h100, 32'h0000_1100, 1, 7),    // R7
    mk({20'hFFFFF,5'd9,7'b0010111}, 0, 0, 32'h2000, 32'h0000_1000, 1, 7),        // R7
    mk(i_ins(12'h000,3'b000,5'd0), 32'h0, 0, 0, 32'h0, 0, 8),                    // R8 nop
    mk({12'h010,5'd1,3'b010,5'd3,7'b0000011}, 32'h10, 0, 0, 32'h0, 0, 8),        // R8 load
    mk({7'd0,5'd2,5'd1,3'b000,5'd0,7'b1100011}, 32'h1, 32'h1, 0, 32'h0, 0, 8)    // R8 branch
  };

  task automatic check(string tag, logic [31:0] exp_r, logic exp_w);
    n_chk++;
    if (res !== exp_r || we !== exp_w) begin
      n_bad++;
      $display("FAIL %s: instr=%h result=%h we=%b expected result=%h we=%b",
               tag, instr, res, we, exp_r, exp_w);
    end
  endtask

  task automatic apply(logic [31:0] i, a, b, p);
    @(posedge clk);
    instr = i; rs1 = a; rs2 = b; pc = p;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    instr = '0; rs1 = '0; rs2 = '0; pc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 reset-state zero word", 32'h0, 1'b0);
    rst_ni = 1'b1;

    for (int k = 0; k < NV; k++) begin
      apply(VEC[k].ins, VEC[k].a, VEC[k].b, VEC[k].pc);
      check($sformatf("R%0d vector %0d", VEC[k].req, k), VEC[k].exp, VEC[k].we);
    end

    // R8: rd = x0 suppresses write for every class, result still computed
    apply(r_ins(0,3'b000,5'd0), 32'h3, 32'h4, 0);
    check("R8 add to x0", 32'h7, 1'b0);
    apply({20'h12345,5'd0,7'b0110111}, 0, 0, 0);
    check("R8 lui to x0", 32'h1234_5000, 1'b0);
    // R5: full-width arithmetic shift keeps sign everywhere
    apply(i_ins(12'h41F,3'b101,5'd2), 32'h8000_0000, 0, 0);
    check("R5 srai 31", 32'hFFFF_FFFF, 1'b1);
    apply(i_ins(12'h01F,3'b001,5'd2), 32'h0000_0003, 0, 0);
    check("R5 slli 31", 32'h8000_0000, 1'b1);
    // R1: subtract wrapping past minimum
    apply(r_ins(1,3'b000,5'd2), 32'h8000_0000, 32'h1, 0);
    check("R1 sub wrap", 32'h7FFF_FFFF, 1'b1);
    // R2: equal operands are not less
    apply(r_ins(0,3'b010,5'd2), 32'h8000_0000, 32'h8000_0000, 0);
    check("R2 equal", 32'h0, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule